// File: doc/BRIEF.md
# Third-Order Bitstream Decimator

This block turns a one-bit sigma-delta stream into unsigned 16-bit samples at a lower rate. The density of ones in the stream carries the signal level. A third-order cascaded integrator-comb filter does the work: three running integrators work at the bit rate, and three differencing stages run once per output word. A two-bit select input chooses a decimation ratio R of 64, 128 or 256 while the block runs. Whatever the ratio, a per-ratio right shift puts the result on the same code scale: a density of d gives a code near 65536·d. The one code that would overflow 16 bits, all ones, is clamped to 65535.

Everything runs in the single modulator clock domain. Reset is synchronous and active high. Reset, or any change of the select value, empties the filter. The block then holds back its first three words, because the comb history is incomplete until then. Control is a two-state machine. FILL is entered on every clear. It counts the suppressed decimation points and moves to RUN at the third one (transition FILL→RUN). RUN emits a word at every decimation point and leaves only through a clear (transition RUN→FILL). A clear also restarts FILL from its first count.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is high and in the cycle after it, `word_valid` is 0 and `word_out` is 0.
- R2: The select encodes R as 00 → 64, 01 → 128, 10 or 11 → 256. In steady operation `word_valid` is a single-cycle pulse every R clocks, never high two cycles in a row.
- R3: After a clear, the first three decimation points produce no pulse. The first pulse comes 4·R clocks after the clearing edge.
- R4: A 50% ones density (alternating bits) gives code 32768 at every ratio.
- R5: A density of 13/16 gives code 53248, and a density of 3/16 gives code 12288, at every ratio.
- R6: An all-ones stream gives 65535 (clamped, not wrapped), and an all-zeros stream gives 0, at every ratio.
- R7: Any change of the select value, including 10 to 11, clears the filter and restarts the three-word fill. The bit present in the clearing cycle is discarded.
- R8: `word_out` changes only in the cycle where `word_valid` is high (or on reset), and it holds its value between pulses.
- R9: Each emitted word equals the response of three cascaded length-R moving sums over the bits since the last clear, divided by R³/65536 with the remainder dropped, and clamped to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_bit | input | 1 | Sigma-delta data bit, sampled each clock |
| rate_sel | input | 2 | Decimation ratio select |
| word_out | output | 16 | Unsigned decimated sample |
| word_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
After a clear, the clock edges are counted from 1, and the n-th bit feeds the edge of the same number. A decimation point falls on every edge whose number is a multiple of R. The comb reads the third integrator as it stood before that edge, so a word reflects the bits up to three edges earlier. The word and its strobe register on that same edge. The bench model applies each clock's inputs as they are driven at the falling edge, and it compares both outputs at the next falling edge, one edge later. The first strobe after a clear is expected exactly 4·R edges after the clearing edge. The fixed density codes are checked 5·R edges into each pattern, once the filter window holds only that pattern.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    typedef enum logic [1:0] {
        RATE_64    = 2'b00,
        RATE_128   = 2'b01,
        RATE_256   = 2'b10,
        RATE_256_B = 2'b11
    } rate_code_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } dec_state_e;

    // log2 of the decimation ratio for a select code
    function automatic int rate_log(input logic [1:0] sel, input int log_max);
        int l;
        unique case (sel)
            RATE_64:  l = log_max - 2;
            RATE_128: l = log_max - 1;
            default:  l = log_max;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ACC_W  = 25,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             sd_bit,
    output logic [ACC_W-1:0] acc_out
);

    for (genvar g = 0; g < STAGES; g++) begin : g_st
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] addend;

        if (g == 0) begin : g_first
            assign addend = {{(ACC_W-1){1'b0}}, sd_bit};
        end else begin : g_next
            assign addend = g_st[g-1].acc_q;
        end

        always_ff @(posedge clk) begin
            if (clr) begin
                acc_q <= '0;
            end else begin
                acc_q <= acc_q + addend;
            end
        end
    end

    assign acc_out = g_st[STAGES-1].acc_q;

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ACC_W  = 25,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    for (genvar g = 0; g < STAGES; g++) begin : g_st
        logic [ACC_W-1:0] stage_in;
        logic [ACC_W-1:0] hist_q;
        logic [ACC_W-1:0] diff;

        if (g == 0) begin : g_first
            assign stage_in = din;
        end else begin : g_next
            assign stage_in = g_st[g-1].diff;
        end

        assign diff = stage_in - hist_q;

        always_ff @(posedge clk) begin
            if (clr) begin
                hist_q <= '0;
            end else if (en) begin
                hist_q <= stage_in;
            end
        end
    end

    assign dout = g_st[STAGES-1].diff;

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int LOG_R_MAX = 8,
    parameter int STAGES    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       clr,
    output logic       strobe,
    output logic       emit,
    output logic [1:0] sel_now
);

    localparam int CNT_W  = LOG_R_MAX;
    localparam int FILL_W = $clog2(STAGES + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(STAGES - 1);

    logic [1:0]        sel_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  r_last;
    logic [FILL_W-1:0] fill_q, fill_d;
    dec_state_e        state_q, state_d;
    logic              chg;

    assign chg     = (rate_sel != sel_q);
    assign clr     = rst | chg;
    assign sel_now = sel_q;

    always_comb begin
        r_last = CNT_W'((1 << rate_log(sel_q, LOG_R_MAX)) - 1);
    end

    assign strobe = !clr && (cnt_q == r_last);

    always_ff @(posedge clk) begin
        if (clr) begin
            sel_q <= rate_sel;
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        emit    = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (strobe) begin
                    if (fill_q == FILL_LAST) begin
                        state_d = ST_RUN;
                        fill_d  = '0;
                    end else begin
                        fill_d = fill_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                emit = strobe;
            end
            default: begin
                state_d = ST_FILL;
            end
        endcase
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= r_last); // R2

    AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (rst)
        $past(chg) |-> (cnt_q == '0 && state_q == ST_FILL)); // R7

    AST_FILL_EXIT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_FILL) |-> $past(strobe)); // R3

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int LOG_R_MAX = 8,
    parameter int OUT_W     = 16,
    parameter int STAGES    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sd_bit,
    input  logic [1:0]       rate_sel,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid
);

    localparam int ACC_W = STAGES * LOG_R_MAX + 1;
    localparam int SH_W  = $clog2(ACC_W);

    logic             clr, strobe, emit;
    logic [1:0]       sel_now;
    logic [ACC_W-1:0] integ_out, comb_out, scaled;
    logic [SH_W-1:0]  shift_amt;
    logic [OUT_W-1:0] sat_word;
    logic [OUT_W-1:0] word_q;
    logic             valid_q;

    sinc3_ctrl #(.LOG_R_MAX(LOG_R_MAX), .STAGES(STAGES)) u_ctrl (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .clr(clr), .strobe(strobe), .emit(emit), .sel_now(sel_now)
    );

    sinc3_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
        .clk(clk), .clr(clr), .sd_bit(sd_bit), .acc_out(integ_out)
    );

    sinc3_comb #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
        .clk(clk), .clr(clr), .en(strobe), .din(integ_out), .dout(comb_out)
    );

    // normalise every ratio onto the same output scale
    always_comb begin
        shift_amt = SH_W'(STAGES * rate_log(sel_now, LOG_R_MAX) - OUT_W);
        scaled    = comb_out >> shift_amt;
        sat_word  = (|scaled[ACC_W-1:OUT_W]) ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= emit;
            if (emit) begin
                word_q <= sat_word;
            end
        end
    end

    assign word_out   = word_q;
    assign word_valid = valid_q;

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(word_q)); // R8

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R2

endmodule

// File: tb/sim_sinc3_decimator.sv
module sim_sinc3_decimator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sd_bit = 1'b0;
    logic [1:0]  rate_sel = 2'b10;
    logic [15:0] word_out;
    logic        word_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sinc3_decimator u0 (
        .clk(clk), .rst(rst), .sd_bit(sd_bit), .rate_sel(rate_sel),
        .word_out(word_out), .word_valid(word_valid)
    );

    // behavioural reference state
    bit          armed = 0;
    bit          hist[$];
    int          m_e = 0;
    int          m_k = 0;
    logic [1:0]  m_sel = 2'b10;
    logic        exp_valid = 1'b0;
    logic [15:0] exp_word = 16'd0;
    bit          first_seen = 0;
    bit          clr_by_sel = 0;
    int          phase = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int lg(input logic [1:0] s);
        return (s == 2'b00) ? 6 : ((s == 2'b01) ? 7 : 8);
    endfunction

    function automatic longint tnum(input longint n);
        return (n <= 0) ? 64'sd0 : (n * (n + 1)) / 2;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_step(input bit r, input logic [1:0] s, input bit b);
        int     rr;
        int     lo;
        longint y;
        longint a;
        if (r || s != m_sel) begin
            clr_by_sel = !r;
            hist.delete();
            m_e = 0;
            m_k = 0;
            m_sel = s;
            exp_valid = 1'b0;
            first_seen = 0;
            if (r) exp_word = 16'd0;
        end else begin
            rr = 1 << lg(m_sel);
            m_e++;
            hist.push_back(b);
            exp_valid = 1'b0;
            if (m_e % rr == 0) begin
                m_k++;
                if (m_k >= 4) begin
                    y  = 0;
                    lo = m_e - 2 - 3 * rr;
                    if (lo < 1) lo = 1;
                    for (int i = lo; i <= m_e - 3; i++) begin
                        if (hist[i-1]) begin
                            a = m_e - 2 - i;
                            y += tnum(a) - 3 * tnum(a - rr) + 3 * tnum(a - 2 * rr) - tnum(a - 3 * rr);
                        end
                    end
                    y = y >>> (3 * lg(m_sel) - 16);
                    exp_word  = (y > 65535) ? 16'hFFFF : 16'(y);
                    exp_valid = 1'b1;
                end
            end
        end
    endtask

    task automatic compare();
        int rr;
        check(word_valid === exp_valid, "R2", longint'(word_valid), longint'(exp_valid));
        check(word_out === exp_word, exp_valid ? "R9" : "R8", longint'(word_out), longint'(exp_word));
        if (word_valid === 1'b1 && !first_seen) begin
            first_seen = 1;
            rr = 1 << lg(m_sel);
            check(m_e == 4 * rr, clr_by_sel ? "R7" : "R3", m_e, 4 * rr);
        end
    endtask

    task automatic tick(input bit r, input logic [1:0] s, input bit b);
        @(negedge clk);
        if (armed) compare();
        rst = r;
        rate_sel = s;
        sd_bit = b;
        model_step(r, s, b);
        armed = 1;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    function automatic bit pat(input int p);
        case (p)
            0: return phase[0];
            1: return (phase % 16) < 13;
            2: return (phase % 16) < 3;
            3: return 1'b1;
            4: return 1'b0;
            default: return lfsr[0];
        endcase
    endfunction

    initial begin
        int rr;
        int expc [5] = '{32768, 53248, 12288, 65535, 0};
        string tags [5] = '{"R4", "R5", "R5", "R6", "R6"};
        logic [1:0] sels [3] = '{2'b10, 2'b01, 2'b00};

        repeat (3) tick(1'b1, 2'b10, 1'b0);
        settle();
        check(word_valid === 1'b0, "R1", longint'(word_valid), 0);
        check(word_out === 16'd0, "R1", longint'(word_out), 0);

        foreach (sels[si]) begin
            rr = 1 << lg(sels[si]);
            for (int p = 0; p < 6; p++) begin
                repeat (5 * rr) begin
                    tick(1'b0, sels[si], pat(p));
                    phase++;
                    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
                end
                settle();
                if (p < 5) check(word_out === 16'(expc[p]), tags[p], longint'(word_out), expc[p]);
            end
        end

        // mid-stream reset
        repeat (2) tick(1'b1, 2'b00, 1'b1);
        settle();
        check(word_valid === 1'b0, "R1", longint'(word_valid), 0);
        check(word_out === 16'd0, "R1", longint'(word_out), 0);

        // select 10 then 11: both ratio 256, the change still clears
        repeat (5 * 256) tick(1'b0, 2'b10, 1'b1);
        repeat (5 * 256) tick(1'b0, 2'b11, 1'b1);
        settle();
        check(word_out === 16'hFFFF, "R7", longint'(word_out), 65535);
        check(first_seen == 1, "R7", longint'(first_seen), 1);

        tick(1'b0, 2'b11, 1'b0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule